// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Stall Unit

This control block sits beside the datapath of a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). For every source operand of the instruction now in execute, it chooses where the operand value comes from. The three sources are the register file, the result held in the execute-to-memory pipeline register, and the result held in the memory-to-writeback pipeline register. The choice depends on the destination register numbers and write enables of the two older instructions. The nearer of the two producers always takes priority.

A load computes only its address in execute, so its data cannot be forwarded to the instruction directly behind it. The unit detects a load in execute whose destination is read by the instruction in decode. It then raises a stall for exactly one cycle, and in that cycle the program counter and the fetch/decode register hold their values. It also raises a bubble request in the same cycle, and the pipeline writes a no-op with cleared write enables into the decode/execute register. Two cycles later the load sits in writeback, its data is forwarded from the memory-to-writeback register, and no further stall is needed.

The one-cycle limit comes from a two-state controller. In the state `ST_RUN` a detected hazard raises the stall, and the transition `RUN_TO_HOLD` is taken at the next clock edge. In the state `ST_HOLD` the stall is suppressed, and the transition `HOLD_TO_RUN` is always taken at the next edge. In `ST_RUN` with no hazard the transition `RUN_STAY` is taken. Reset enters `ST_RUN`.

Top module: `fwd_hazard_unit`

## Requirements
- R1: Each operand select `fwd_sel_o[2k+1:2k]` (operand k, k=0 first) uses the code 0 for the register file, 1 for the execute-to-memory register (the instruction in memory) and 2 for the memory-to-writeback register (the instruction in writeback). The code 3 never appears.
- R2: When the instruction in memory has write enable set, is not a load, and its destination equals operand k's nonzero source register, the select for operand k is 1.
- R3: When only the instruction in writeback has write enable set with a destination equal to operand k's nonzero source register, the select for operand k is 2.
- R4: When both the memory and writeback instructions write operand k's source register, the select is 1, because the younger producer wins.
- R5: When the matching instruction in memory is a load, its address is never forwarded. The select for that operand is 0, and no older writeback result is used in its place.
- R6: Source or destination register 0 never produces a forwarding match or a stall.
- R7: A stage whose write enable is low never produces a forwarding match or a stall, even when its destination number matches.
- R8: A load in execute with write enable set, whose nonzero destination equals either source register of the instruction in decode, raises `stall_o` and `bubble_o` in that same cycle while the controller is in `ST_RUN`.
- R9: A stall lasts exactly one cycle. In the cycle after a stall both `stall_o` and `bubble_o` are low even if the hazard inputs persist, and in the cycle after that a persisting hazard stalls again.
- R10: An instruction in execute that is not a load never causes a stall, even when it writes a register read in decode.
- R11: After reset the controller is in `ST_RUN`, all selects are 0 with idle inputs, and the first hazard after reset stalls at once.
- R12: The result in writeback is forwarded with code 2 regardless of the kind of instruction, so a load's data reaches the dependent instruction after the one-cycle stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| id_src_i | input | NUM_SRC*REG_AW | Source register numbers of the instruction in decode, operand 0 in the low bits |
| ex_src_i | input | NUM_SRC*REG_AW | Source register numbers of the instruction in execute, operand 0 in the low bits |
| ex_rd_i | input | REG_AW | Destination register of the instruction in execute |
| ex_wen_i | input | 1 | Register-write enable of the instruction in execute |
| ex_load_i | input | 1 | Instruction in execute is a load |
| mem_rd_i | input | REG_AW | Destination register of the instruction in memory |
| mem_wen_i | input | 1 | Register-write enable of the instruction in memory |
| mem_load_i | input | 1 | Instruction in memory is a load |
| wb_rd_i | input | REG_AW | Destination register of the instruction in writeback |
| wb_wen_i | input | 1 | Register-write enable of the instruction in writeback |
| fwd_sel_o | output | NUM_SRC*2 | Per-operand source select, codes as in R1 |
| stall_o | output | 1 | Hold program counter and fetch/decode register this cycle |
| bubble_o | output | 1 | Load a no-op into the decode/execute register this cycle |

## Verification
The bench builds the block with its default parameters: 32 registers (REG_AW = 5) and two source operands. With these values both operand lanes of the generate loop are present, so a hazard on the second operand and a double match on both operands can be tried alongside the first. Register numbers in the random phase are drawn from a small range, so matches between stages, register-0 collisions and load/use pairs occur often. A scoreboard then compares the selects and the stall against a model of the two-state controller.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    typedef enum logic [1:0] {
        SRC_RF  = 2'd0,
        SRC_EXM = 2'd1,
        SRC_MWB = 2'd2
    } src_sel_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HOLD = 1'b1
    } stall_st_e;

    localparam int unsigned SEL_W = 2;

endpackage

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel
    import fwd_pkg::*;
#(
    parameter int unsigned REG_AW = 5
) (
    input  logic [REG_AW-1:0] src_i,
    input  logic [REG_AW-1:0] mem_rd_i,
    input  logic              mem_wen_i,
    input  logic              mem_load_i,
    input  logic [REG_AW-1:0] wb_rd_i,
    input  logic              wb_wen_i,
    output src_sel_e          sel_o
);

    logic src_live;
    logic hit_mem;
    logic hit_wb;

    // register 0 is hardwired, so it never matches a producer
    assign src_live = (src_i != '0);
    assign hit_mem  = src_live && mem_wen_i && (mem_rd_i == src_i);
    assign hit_wb   = src_live && wb_wen_i  && (wb_rd_i  == src_i);

    always_comb begin
        sel_o = SRC_RF;
        if (hit_mem) begin
            // younger producer owns the register; a load holds only an address here
            sel_o = mem_load_i ? SRC_RF : SRC_EXM;
        end else if (hit_wb) begin
            sel_o = SRC_MWB;
        end
    end

endmodule

// File: rtl/load_use_detect.sv
module load_use_detect #(
    parameter int unsigned REG_AW  = 5,
    parameter int unsigned NUM_SRC = 2
) (
    input  logic [NUM_SRC*REG_AW-1:0] id_src_i,
    input  logic [REG_AW-1:0]         ex_rd_i,
    input  logic                      ex_wen_i,
    input  logic                      ex_load_i,
    output logic                      hazard_o
);

    logic              producer_ok;
    logic [NUM_SRC-1:0] src_hit;

    assign producer_ok = ex_load_i && ex_wen_i && (ex_rd_i != '0);

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
        assign src_hit[k] = (id_src_i[k*REG_AW +: REG_AW] == ex_rd_i);
    end

    assign hazard_o = producer_ok && (|src_hit);

endmodule

// File: rtl/stall_fsm.sv
module stall_fsm
    import fwd_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic hazard_i,
    output logic stall_o,
    output logic bubble_o
);

    stall_st_e state_q;
    stall_st_e state_d;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: RUN_STAY, RUN_TO_HOLD, HOLD_TO_RUN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  state_d = hazard_i ? ST_HOLD : ST_RUN;
            ST_HOLD: state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        stall_o  = 1'b0;
        bubble_o = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                stall_o  = hazard_i;
                bubble_o = hazard_i;
            end
            ST_HOLD: begin
                stall_o  = 1'b0;
                bubble_o = 1'b0;
            end
            default: begin
                stall_o  = 1'b0;
                bubble_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit
    import fwd_pkg::*;
#(
    parameter int unsigned REG_AW  = 5,
    parameter int unsigned NUM_SRC = 2
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic [NUM_SRC*REG_AW-1:0] id_src_i,
    input  logic [NUM_SRC*REG_AW-1:0] ex_src_i,
    input  logic [REG_AW-1:0]         ex_rd_i,
    input  logic                      ex_wen_i,
    input  logic                      ex_load_i,
    input  logic [REG_AW-1:0]         mem_rd_i,
    input  logic                      mem_wen_i,
    input  logic                      mem_load_i,
    input  logic [REG_AW-1:0]         wb_rd_i,
    input  logic                      wb_wen_i,
    output logic [NUM_SRC*SEL_W-1:0]  fwd_sel_o,
    output logic                      stall_o,
    output logic                      bubble_o
);

    localparam int unsigned SRC_BUS_W = NUM_SRC * REG_AW;

    logic                 hazard;
    logic [SRC_BUS_W-1:0] ex_src_bus;

    assign ex_src_bus = ex_src_i;

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_opnd
        src_sel_e sel_k;

        fwd_operand_sel #(
            .REG_AW (REG_AW)
        ) u_sel (
            .src_i      (ex_src_bus[k*REG_AW +: REG_AW]),
            .mem_rd_i   (mem_rd_i),
            .mem_wen_i  (mem_wen_i),
            .mem_load_i (mem_load_i),
            .wb_rd_i    (wb_rd_i),
            .wb_wen_i   (wb_wen_i),
            .sel_o      (sel_k)
        );

        assign fwd_sel_o[k*SEL_W +: SEL_W] = sel_k;
    end

    load_use_detect #(
        .REG_AW  (REG_AW),
        .NUM_SRC (NUM_SRC)
    ) u_detect (
        .id_src_i  (id_src_i),
        .ex_rd_i   (ex_rd_i),
        .ex_wen_i  (ex_wen_i),
        .ex_load_i (ex_load_i),
        .hazard_o  (hazard)
    );

    stall_fsm u_fsm (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .hazard_i (hazard),
        .stall_o  (stall_o),
        .bubble_o (bubble_o)
    );

endmodule

// File: rtl/fwd_hazard_unit_chk.sv
module fwd_hazard_unit_chk #(
    parameter int unsigned REG_AW  = 5,
    parameter int unsigned NUM_SRC = 2
) (
    input logic                      clk_i,
    input logic                      rst_ni,
    input logic [NUM_SRC*REG_AW-1:0] id_src_i,
    input logic [NUM_SRC*REG_AW-1:0] ex_src_i,
    input logic [REG_AW-1:0]         ex_rd_i,
    input logic                      ex_wen_i,
    input logic                      ex_load_i,
    input logic [REG_AW-1:0]         mem_rd_i,
    input logic                      mem_wen_i,
    input logic                      mem_load_i,
    input logic [REG_AW-1:0]         wb_rd_i,
    input logic                      wb_wen_i,
    input logic [NUM_SRC*2-1:0]      fwd_sel_o,
    input logic                      stall_o,
    input logic                      bubble_o
);

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_chk
        assert_sel_legal_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
            fwd_sel_o[2*k +: 2] != 2'd3);

        assert_zero_src_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (ex_src_i[k*REG_AW +: REG_AW] == '0) |-> (fwd_sel_o[2*k +: 2] == 2'd0));

        assert_exm_producer_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (fwd_sel_o[2*k +: 2] == 2'd1) |->
                (mem_wen_i && !mem_load_i && mem_rd_i == ex_src_i[k*REG_AW +: REG_AW]));

        assert_mwb_producer_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (fwd_sel_o[2*k +: 2] == 2'd2) |->
                (wb_wen_i && wb_rd_i == ex_src_i[k*REG_AW +: REG_AW]));

        assert_no_load_addr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (mem_load_i && mem_wen_i && mem_rd_i != '0 &&
             mem_rd_i == ex_src_i[k*REG_AW +: REG_AW]) |-> (fwd_sel_o[2*k +: 2] == 2'd0));
    end

    assert_one_cycle_stall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stall_o |=> (!stall_o && !bubble_o));

    assert_stall_needs_load_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stall_o |-> (ex_load_i && ex_wen_i && ex_rd_i != '0));

    assert_stall_has_reader_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stall_o |-> (id_src_i[REG_AW-1:0] == ex_rd_i ||
                     id_src_i[NUM_SRC*REG_AW-1 -: REG_AW] == ex_rd_i || NUM_SRC > 2));

endmodule

bind fwd_hazard_unit fwd_hazard_unit_chk #(
    .REG_AW  (REG_AW),
    .NUM_SRC (NUM_SRC)
) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .id_src_i   (id_src_i),
    .ex_src_i   (ex_src_i),
    .ex_rd_i    (ex_rd_i),
    .ex_wen_i   (ex_wen_i),
    .ex_load_i  (ex_load_i),
    .mem_rd_i   (mem_rd_i),
    .mem_wen_i  (mem_wen_i),
    .mem_load_i (mem_load_i),
    .wb_rd_i    (wb_rd_i),
    .wb_wen_i   (wb_wen_i),
    .fwd_sel_o  (fwd_sel_o),
    .stall_o    (stall_o),
    .bubble_o   (bubble_o)
);

// File: tb/fwd_hazard_unit_tb_top.sv
module fwd_hazard_unit_tb_top;

    localparam int unsigned AW = 5;
    localparam int unsigned NS = 2;
    localparam int unsigned NV = 14;

    // {ex_s0, ex_s1, ex_rd, ex_w, ex_l, mem_rd, mem_w, mem_l, wb_rd, wb_w,
    //  id_s0, id_s1, exp_sel0, exp_sel1, exp_stall, req}
    localparam logic [48:0] VEC [NV] = '{
        {5'd3,  5'd4,  5'd0,  1'b0, 1'b0, 5'd3,  1'b1, 1'b0, 5'd0,  1'b0, 5'd0,  5'd0,  2'd1, 2'd0, 1'b0, 4'd2},
        {5'd5,  5'd7,  5'd0,  1'b0, 1'b0, 5'd7,  1'b1, 1'b0, 5'd0,  1'b0, 5'd0,  5'd0,  2'd0, 2'd1, 1'b0, 4'd2},
        {5'd6,  5'd2,  5'd0,  1'b0, 1'b0, 5'd9,  1'b1, 1'b0, 5'd6,  1'b1, 5'd0,  5'd0,  2'd2, 2'd0, 1'b0, 4'd3},
        {5'd8,  5'd8,  5'd0,  1'b0, 1'b0, 5'd1,  1'b1, 1'b0, 5'd8,  1'b1, 5'd0,  5'd0,  2'd2, 2'd2, 1'b0, 4'd3},
        {5'd10, 5'd10, 5'd0,  1'b0, 1'b0, 5'd10, 1'b1, 1'b0, 5'd10, 1'b1, 5'd0,  5'd0,  2'd1, 2'd1, 1'b0, 4'd4},
        {5'd11, 5'd2,  5'd0,  1'b0, 1'b0, 5'd11, 1'b1, 1'b1, 5'd11, 1'b1, 5'd0,  5'd0,  2'd0, 2'd0, 1'b0, 4'd5},
        {5'd0,  5'd0,  5'd0,  1'b0, 1'b0, 5'd0,  1'b1, 1'b0, 5'd0,  1'b1, 5'd0,  5'd0,  2'd0, 2'd0, 1'b0, 4'd6},
        {5'd12, 5'd13, 5'd0,  1'b0, 1'b0, 5'd12, 1'b0, 1'b0, 5'd13, 1'b0, 5'd0,  5'd0,  2'd0, 2'd0, 1'b0, 4'd7},
        {5'd1,  5'd2,  5'd14, 1'b1, 1'b1, 5'd0,  1'b0, 1'b0, 5'd0,  1'b0, 5'd14, 5'd3,  2'd0, 2'd0, 1'b1, 4'd8},
        {5'd1,  5'd2,  5'd15, 1'b1, 1'b1, 5'd0,  1'b0, 1'b0, 5'd0,  1'b0, 5'd4,  5'd15, 2'd0, 2'd0, 1'b1, 4'd8},
        {5'd1,  5'd2,  5'd16, 1'b1, 1'b0, 5'd0,  1'b0, 1'b0, 5'd0,  1'b0, 5'd16, 5'd16, 2'd0, 2'd0, 1'b0, 4'd10},
        {5'd0,  5'd0,  5'd0,  1'b1, 1'b1, 5'd0,  1'b0, 1'b0, 5'd0,  1'b0, 5'd0,  5'd0,  2'd0, 2'd0, 1'b0, 4'd6},
        {5'd17, 5'd3,  5'd0,  1'b0, 1'b0, 5'd0,  1'b0, 1'b0, 5'd17, 1'b1, 5'd0,  5'd0,  2'd2, 2'd0, 1'b0, 4'd12},
        {5'd0,  5'd0,  5'd18, 1'b0, 1'b1, 5'd0,  1'b0, 1'b0, 5'd0,  1'b0, 5'd18, 5'd0,  2'd0, 2'd0, 1'b0, 4'd7}
    };

    logic              clk_i = 1'b0;
    logic              rst_ni = 1'b0;
    logic [NS*AW-1:0]  id_src_i = '0;
    logic [NS*AW-1:0]  ex_src_i = '0;
    logic [AW-1:0]     ex_rd_i = '0;
    logic              ex_wen_i = 1'b0;
    logic              ex_load_i = 1'b0;
    logic [AW-1:0]     mem_rd_i = '0;
    logic              mem_wen_i = 1'b0;
    logic              mem_load_i = 1'b0;
    logic [AW-1:0]     wb_rd_i = '0;
    logic              wb_wen_i = 1'b0;
    logic [NS*2-1:0]   fwd_sel_o;
    logic              stall_o;
    logic              bubble_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk_i = ~clk_i;

    fwd_hazard_unit #(.REG_AW(AW), .NUM_SRC(NS)) dut_i (
        .clk_i, .rst_ni, .id_src_i, .ex_src_i, .ex_rd_i, .ex_wen_i, .ex_load_i,
        .mem_rd_i, .mem_wen_i, .mem_load_i, .wb_rd_i, .wb_wen_i,
        .fwd_sel_o, .stall_o, .bubble_o
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle();
        id_src_i = '0; ex_src_i = '0; ex_rd_i = '0; ex_wen_i = 1'b0; ex_load_i = 1'b0;
        mem_rd_i = '0; mem_wen_i = 1'b0; mem_load_i = 1'b0; wb_rd_i = '0; wb_wen_i = 1'b0;
    endtask

    // reference select from R2..R7 and R12
    function automatic logic [1:0] ref_sel(input logic [AW-1:0] s);
        if (s != 0 && mem_wen_i && mem_rd_i == s) return mem_load_i ? 2'd0 : 2'd1;
        if (s != 0 && wb_wen_i && wb_rd_i == s) return 2'd2;
        return 2'd0;
    endfunction

    function automatic bit ref_hazard();
        return ex_load_i && ex_wen_i && ex_rd_i != 0 &&
               (id_src_i[AW-1:0] == ex_rd_i || id_src_i[2*AW-1:AW] == ex_rd_i);
    endfunction

    task automatic drive_vec(input logic [48:0] v);
        ex_src_i   = {v[43:39], v[48:44]};
        ex_rd_i    = v[38:34];
        ex_wen_i   = v[33];
        ex_load_i  = v[32];
        mem_rd_i   = v[31:27];
        mem_wen_i  = v[26];
        mem_load_i = v[25];
        wb_rd_i    = v[24:20];
        wb_wen_i   = v[19];
        id_src_i   = {v[13:9], v[18:14]};
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        bit hold_m;
        idle();
        repeat (3) @(posedge clk_i);
        @(negedge clk_i);
        #1;
        // R11: reset state
        check(stall_o == 1'b0 && bubble_o == 1'b0, "R11 stall in reset", stall_o, 0);
        check(fwd_sel_o == '0, "R11 selects in reset", fwd_sel_o, 0);
        @(negedge clk_i);
        rst_ni = 1'b1;

        // R11: first hazard after reset stalls at once
        drive_vec(VEC[8]);
        #1;
        check(stall_o == 1'b1 && bubble_o == 1'b1, "R11 first hazard", stall_o, 1);
        @(negedge clk_i); idle();
        @(negedge clk_i);

        // table walk, one idle cycle after every vector
        for (int i = 0; i < NV; i++) begin
            drive_vec(VEC[i]);
            #1;
            check(fwd_sel_o[1:0] == VEC[i][8:7],
                  $sformatf("R%0d sel0 vec%0d", VEC[i][3:0], i), fwd_sel_o[1:0], VEC[i][8:7]);
            check(fwd_sel_o[3:2] == VEC[i][6:5],
                  $sformatf("R%0d sel1 vec%0d", VEC[i][3:0], i), fwd_sel_o[3:2], VEC[i][6:5]);
            check(stall_o == VEC[i][4] && bubble_o == VEC[i][4],
                  $sformatf("R%0d stall vec%0d", VEC[i][3:0], i), stall_o, VEC[i][4]);
            check(fwd_sel_o[1:0] != 2'd3 && fwd_sel_o[3:2] != 2'd3, "R1 legal code", fwd_sel_o, 0);
            @(negedge clk_i); idle();
            @(negedge clk_i);
        end

        // R9: persisting hazard stalls, drops for one cycle, stalls again
        drive_vec(VEC[9]);
        #1;
        check(stall_o == 1'b1, "R9 first stall", stall_o, 1);
        @(negedge clk_i); #1;
        check(stall_o == 1'b0 && bubble_o == 1'b0, "R9 hold cycle", stall_o, 0);
        @(negedge clk_i); #1;
        check(stall_o == 1'b1, "R9 restall", stall_o, 1);
        @(negedge clk_i); idle();
        @(negedge clk_i);

        // R12: load-use sequence: stall, bubble cycle, then forward from writeback
        ex_rd_i = 5'd20; ex_wen_i = 1'b1; ex_load_i = 1'b1; id_src_i = {5'd0, 5'd20};
        #1;
        check(stall_o == 1'b1, "R12 stall for load", stall_o, 1);
        @(negedge clk_i);
        idle();
        mem_rd_i = 5'd20; mem_wen_i = 1'b1; mem_load_i = 1'b1; id_src_i = {5'd0, 5'd20};
        #1;
        check(stall_o == 1'b0, "R12 no second stall", stall_o, 0);
        @(negedge clk_i);
        idle();
        wb_rd_i = 5'd20; wb_wen_i = 1'b1; ex_src_i = {5'd0, 5'd20};
        #1;
        check(fwd_sel_o[1:0] == 2'd2, "R12 load data from writeback", fwd_sel_o[1:0], 2);
        @(negedge clk_i); idle();
        @(negedge clk_i);

        // random scoreboard over R2..R10
        hold_m = 1'b0;
        for (int n = 0; n < 400; n++) begin
            logic [1:0] e0, e1;
            bit es;
            ex_src_i   = {AW'($urandom_range(0, 3)), AW'($urandom_range(0, 3))};
            id_src_i   = {AW'($urandom_range(0, 3)), AW'($urandom_range(0, 3))};
            ex_rd_i    = AW'($urandom_range(0, 3));
            ex_wen_i   = 1'($urandom_range(0, 1));
            ex_load_i  = 1'($urandom_range(0, 1));
            mem_rd_i   = AW'($urandom_range(0, 3));
            mem_wen_i  = 1'($urandom_range(0, 1));
            mem_load_i = 1'($urandom_range(0, 1));
            wb_rd_i    = AW'($urandom_range(0, 3));
            wb_wen_i   = 1'($urandom_range(0, 1));
            #1;
            e0 = ref_sel(ex_src_i[AW-1:0]);
            e1 = ref_sel(ex_src_i[2*AW-1:AW]);
            es = !hold_m && ref_hazard();
            check(fwd_sel_o[1:0] == e0, "R2-R7 random sel0 (R4)", fwd_sel_o[1:0], e0);
            check(fwd_sel_o[3:2] == e1, "R2-R7 random sel1 (R5)", fwd_sel_o[3:2], e1);
            check(stall_o == es && bubble_o == es, "R8 random stall (R9)", stall_o, es);
            hold_m = es;
            @(negedge clk_i);
        end

        done = 1'b1;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule